// File: doc/BRIEF.md
# Conditional Run Sequencer

This block sits beside an instruction decoder and decides, one instruction at a time, whether the pipeline may carry out the instruction just decoded or must squash it. A special prefix instruction opens a guarded run: it supplies a condition result, taken from the processor status word, plus two lengths. The first length counts the instructions that execute only if the condition was true. The second counts the instructions that follow them, which execute only if the condition was false.

The condition is tested once, when the prefix is accepted, and is held for the whole run. Each valid instruction in a phase uses up one count, whether it executes or is squashed. When both counts are used up the block goes back to letting every instruction through. The block does not evaluate conditions, does not decode, and does not support nested runs.

Top module: `cx_seq`

## Requirements
- R1: `state` is encoded as 0 = idle, 1 = then-phase, 2 = else-phase, and never shows 3. A synchronous `rst` returns the block to idle and clears both counters. The next valid instruction after reset executes.
- R2: In idle, `execEn` equals `instrValid`. In any state, `execEn` is low whenever `instrValid` is low.
- R3: A prefix is accepted only in idle, on a cycle where `instrValid` and `prefixSeen` are both high. The prefix executes itself and does not count toward either run. On the next cycle the state is 1 if `thenCount` is nonzero.
- R4: In the then-phase, a valid instruction executes only if the captured condition is true.
- R5: Every valid instruction in the then-phase uses one count, whether it executes or is squashed. After `thenCount` of them the state moves to 2, or to 0 if the captured `elseCount` is zero.
- R6: In the else-phase, a valid instruction executes only if the captured condition is false. Each one uses one count, and after `elseCount` of them the state returns to 0.
- R7: If a prefix arrives with `thenCount` = 0, the state goes straight to 2. If both counts are zero, the state stays 0.
- R8: Changes on `condTrue` after the prefix have no effect on `execEn` for the rest of the run.
- R9: Cycles with `instrValid` low change neither the state nor any remaining count.
- R10: A prefix strobe seen during a run is treated as an ordinary instruction of that run. It uses one count and captures neither a new condition nor new lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | A decoded instruction is presented this cycle |
| prefixSeen | input | 1 | The presented instruction is a conditional prefix |
| condTrue | input | 1 | Condition result from the status word |
| thenCount | input | CNT_W (4) | Length of the true-guarded run |
| elseCount | input | CNT_W (4) | Length of the false-guarded run |
| execEn | output | 1 | The presented instruction may execute |
| state | output | 2 | Current phase: 0 idle, 1 then, 2 else |

## Verification
The checker watches, on every cycle, that the state encoding stays legal, that nothing executes without a valid instruction, and that idle lets every valid instruction through. It also checks that gaps in the instruction stream freeze the state, that the else-phase never falls back into the then-phase, and that the execute decision stays fixed across consecutive then-phase instructions. Exact run lengths, the skip past an empty else-run, the zero-length cases at prefix time, the handling of a prefix strobe inside a run, and clearing by reset in the middle of a run depend on specific count values. Only the bench's scenarios can show those.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_THEN = 2'd1,
    PH_ELSE = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;
    logic decThen;
    logic decElse;
  } ctrl_strb_t;
endpackage

// File: rtl/cx_dpath.sv
module cx_dpath #(
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  cx_pkg::ctrl_strb_t  strb,
  input  logic                condTrue,
  input  logic [CNT_W-1:0]    thenCount,
  input  logic [CNT_W-1:0]    elseCount,
  output logic                condHeld,
  output logic                thenInZero,
  output logic                elseInZero,
  output logic                thenLast,
  output logic                elseLast,
  output logic                elseLeftZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] thenLeft;
  logic [CNT_W-1:0] elseLeft;

  always_ff @(posedge clk) begin
    if (rst) begin
      thenLeft <= '0;
      elseLeft <= '0;
      condHeld <= 1'b0;
    end else if (strb.load) begin
      thenLeft <= thenCount;
      elseLeft <= elseCount;
      condHeld <= condTrue;
    end else begin
      if (strb.decThen) thenLeft <= thenLeft - ONE;
      if (strb.decElse) elseLeft <= elseLeft - ONE;
    end
  end

  assign thenInZero   = (thenCount == '0);
  assign elseInZero   = (elseCount == '0);
  assign thenLast     = (thenLeft == ONE);
  assign elseLast     = (elseLeft == ONE);
  assign elseLeftZero = (elseLeft == '0);
endmodule

// File: rtl/cx_ctrl.sv
module cx_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic               prefixSeen,
  input  logic               condHeld,
  input  logic               thenInZero,
  input  logic               elseInZero,
  input  logic               thenLast,
  input  logic               elseLast,
  input  logic               elseLeftZero,
  output cx_pkg::ctrl_strb_t strb,
  output cx_pkg::phase_t     phase,
  output logic               execEn
);
  import cx_pkg::*;

  phase_t phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext    = phase;
    strb         = '0;
    execEn       = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        execEn = instrValid;
        if (instrValid && prefixSeen) begin
          strb.load = 1'b1;
          if (!thenInZero)      phaseNext = PH_THEN;
          else if (!elseInZero) phaseNext = PH_ELSE;
        end
      end
      PH_THEN: begin
        execEn = instrValid && condHeld;
        if (instrValid) begin
          strb.decThen = 1'b1;
          if (thenLast) phaseNext = elseLeftZero ? PH_IDLE : PH_ELSE;
        end
      end
      PH_ELSE: begin
        execEn = instrValid && !condHeld;
        if (instrValid) begin
          strb.decElse = 1'b1;
          if (elseLast) phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/cx_seq.sv
module cx_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instrValid,
  input  logic             prefixSeen,
  input  logic             condTrue,
  input  logic [CNT_W-1:0] thenCount,
  input  logic [CNT_W-1:0] elseCount,
  output logic             execEn,
  output logic [1:0]       state
);
  cx_pkg::ctrl_strb_t strb;
  cx_pkg::phase_t     phase;
  logic condHeld, thenInZero, elseInZero, thenLast, elseLast, elseLeftZero;

  cx_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .condTrue(condTrue),
    .thenCount(thenCount), .elseCount(elseCount), .condHeld(condHeld),
    .thenInZero(thenInZero), .elseInZero(elseInZero), .thenLast(thenLast),
    .elseLast(elseLast), .elseLeftZero(elseLeftZero)
  );

  cx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .instrValid(instrValid), .prefixSeen(prefixSeen),
    .condHeld(condHeld), .thenInZero(thenInZero), .elseInZero(elseInZero),
    .thenLast(thenLast), .elseLast(elseLast), .elseLeftZero(elseLeftZero),
    .strb(strb), .phase(phase), .execEn(execEn)
  );

  assign state = phase;
endmodule

// File: rtl/cx_seq_chk.sv
module cx_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       instrValid,
  input logic       execEn,
  input logic [1:0] state
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != 2'd3); // R1
  AST_NO_EXEC_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !execEn); // R2
  AST_IDLE_PASSES_ALL: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && instrValid) |-> execEn); // R2
  AST_IDLE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && !instrValid) |=> state == 2'd0); // R3
  AST_GAP_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (state != 2'd0 && !instrValid) |=> $stable(state)); // R9
  AST_ELSE_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
    state == 2'd2 |=> state != 2'd1); // R6
  AST_THEN_DECISION_FIXED: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && instrValid && $past(state == 2'd1 && instrValid))
      |-> execEn == $past(execEn)); // R8
endmodule

bind cx_seq cx_seq_chk u_chk (
  .clk(clk), .rst(rst), .instrValid(instrValid), .execEn(execEn), .state(state)
);

// File: tb/sim_cx_seq.sv
module sim_cx_seq;
  localparam int CNT_W = 4;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instrValid = 1'b0, prefixSeen = 1'b0, condTrue = 1'b0;
  logic [CNT_W-1:0] thenCount = '0, elseCount = '0;
  logic execEn;
  logic [1:0] state;
  int nChk = 0, nErr = 0;

  always #5 clk = ~clk;

  cx_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .instrValid(instrValid), .prefixSeen(prefixSeen),
    .condTrue(condTrue), .thenCount(thenCount), .elseCount(elseCount),
    .execEn(execEn), .state(state)
  );

  // fields: rst, valid, prefix, cond, thenCount, elseCount, expExec, expStateAfter, req
  localparam logic [18:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,1'b0,1'b0,4'd0,4'd0,1'b0,2'd0,4'd1},   // R1 reset
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd0,4'd2},   // R2 idle runs
    {1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,1'b0,2'd0,4'd2},   // R2 no valid
    {1'b0,1'b1,1'b1,1'b1,4'd2,4'd1,1'b1,2'd1,4'd3},   // R3 prefix true
    {1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,1'b0,2'd1,4'd9},   // R9 gap
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd1,4'd8},   // R8 cond input flips
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd2,4'd5},   // R5 then done
    {1'b0,1'b1,1'b0,1'b1,4'd0,4'd0,1'b0,2'd0,4'd6},   // R6 else squashed
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd0,4'd2},
    {1'b0,1'b1,1'b1,1'b0,4'd1,4'd2,1'b1,2'd1,4'd3},   // R3 prefix false
    {1'b0,1'b1,1'b0,1'b1,4'd0,4'd0,1'b0,2'd2,4'd4},   // R4 squashed, R5 counted
    {1'b0,1'b1,1'b1,1'b1,4'd3,4'd3,1'b1,2'd2,4'd10},  // R10 prefix in run
    {1'b0,1'b1,1'b0,1'b1,4'd0,4'd0,1'b1,2'd0,4'd6},   // R6 else ends
    {1'b0,1'b1,1'b1,1'b1,4'd0,4'd2,1'b1,2'd2,4'd7},   // R7 then empty
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b0,2'd2,4'd6},
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b0,2'd0,4'd6},
    {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,1'b1,2'd0,4'd7},   // R7 both empty
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd0,4'd7},
    {1'b0,1'b1,1'b1,1'b1,4'd1,4'd0,1'b1,2'd1,4'd5},   // R5 else empty
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd0,4'd5},
    {1'b0,1'b1,1'b1,1'b1,4'd3,4'd3,1'b1,2'd1,4'd3},
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd1,4'd4},
    {1'b1,1'b0,1'b0,1'b0,4'd0,4'd0,1'b0,2'd0,4'd1},   // R1 reset mid-run
    {1'b0,1'b1,1'b0,1'b0,4'd0,4'd0,1'b1,2'd0,4'd1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, v, p, c, input logic [3:0] tc, ec,
                      input logic ex, input logic [1:0] st, input string req);
    @(negedge clk);
    rst = r; instrValid = v; prefixSeen = p; condTrue = c;
    thenCount = tc; elseCount = ec;
    #1;
    if (!r) check(req, "execEn", int'(execEn), int'(ex));
    @(posedge clk);
    #1;
    check(req, "state", int'(state), int'(st));
  endtask

  initial begin
    #2_000_000;
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk);
    #1;
    check("R1", "reset state", int'(state), 0);
    for (int i = 0; i < NV; i++) begin
      logic [18:0] w;
      w = VEC[i];
      step(w[18], w[17], w[16], w[15], w[14:11], w[10:7], w[6], w[5:4],
           $sformatf("R%0d", w[3:0]));
    end
    // R5 R6: longest runs, condition true: all then-slots execute, all else-slots squash
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1, 2'd1, "R5");
    for (int k = 1; k <= 15; k++)
      step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, (k == 15) ? 2'd2 : 2'd1, "R5");
    for (int k = 1; k <= 15; k++)
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 1'b0, (k == 15) ? 2'd0 : 2'd2, "R6");
    // R9: long gaps inside else-phase keep the remaining count
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd2, 1'b1, 2'd2, "R9");
    for (int k = 0; k < 5; k++)
      step(1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 2'd2, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 2'd2, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 2'd0, "R9");
    // R3: prefix strobe without a valid instruction is not a prefix
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 4'd3, 1'b0, 2'd0, "R3");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule